// File: doc/BRIEF.md
# Read Prefetch Boundary Controller

This block decides how far a bus bridge reads ahead for one read request. It accepts a request that describes the command, the starting DWORD address, the direction and the prefetch context. It then issues sequential single-DWORD fetches to the target side, one address per accepted fetch, and places each returned word in an internal queue. The initiator side drains that queue through a valid/ready port. The controller flags the final word so that a disconnect can be sent with it.

Fetching ends when the first of these happens. The fetch count reaches the stop point for that command. The target disconnects. The queue fills, but only in the queue-full mode of the read-multiple command. The initiator terminates the request. When the initiator terminates, any words still queued are discarded.

A four-state machine sequences the work:
- `IDLE`: waiting for a request. On `req_valid` it latches the request and moves to `FETCH`.
- `FETCH`: issuing fetches. It moves to `DRAIN` on the final fetch (stop point reached or target disconnect), or when the queue is full in queue-full mode. It moves to `FLUSH` on `ini_term`.
- `DRAIN`: delivering the remaining words. It moves to `IDLE` when the last word is taken, or to `FLUSH` on `ini_term`.
- `FLUSH`: clears the queue for one cycle, then returns to `IDLE`.

Top module: `rdpf_ctrl`

## Requirements
- R1: Command encodings are 0 configuration read, 1 I/O read, 2 memory read, 3 memory read line, 4 memory read multiple. Configuration reads, I/O reads and memory reads that do not prefetch fetch exactly one DWORD.
- R2: A prefetching memory read or a memory read line with cache line size 0 or 16 fetches up to the next 16-DWORD aligned boundary. The fetches are issued at consecutive DWORD addresses starting at the request address, and each delivered word is the data returned for its address, in order.
- R3: A prefetching memory read or a memory read line with cache line size 1, 2, 4 or 8 fetches up to the next boundary aligned to that line size.
- R4: A memory read multiple with cache line size 1, 2, 4 or 8 fetches up to the second line boundary after the start address.
- R5: A downstream memory read (`req_upstream`=0) prefetches only when `req_pref` is 1. An upstream memory read prefetches only when `up_pf_en` is 1, whatever `req_pref` is.
- R6: Any cache line size other than 1, 2, 4 and 8 behaves like 16.
- R7: When `req_flow` is 1, every prefetching read runs to the next 1024-DWORD (4 KB) aligned boundary. A non-prefetching read still fetches one DWORD.
- R8: The stop point is the next aligned boundary strictly above the start address, so an aligned start fetches the whole span.
- R9: A fetch that is accepted with `tgt_disc`=1 is the last fetch of the request.
- R10: `ini_last` is high on the final delivered word of a request that ends without termination, and on no other word.
- R11: No fetch is offered while the queue holds `DEPTH` words. Fetching resumes when the initiator makes room.
- R12: A memory read multiple with any cache line size other than 1, 2, 4 and 8 fetches until the queue is full, and never beyond the next 4 KB boundary.
- R13: `ini_term` while busy stops fetching and discards every queued word. `busy` falls two cycles later, and the next request delivers only its own data.
- R14: `busy` is high from the cycle after acceptance until the cycle after the last word is taken. A `req_valid` seen while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_cmd | input | 3 | Read command code |
| req_addr | input | ADDR_W | Start DWORD address |
| req_pref | input | 1 | Target address lies in prefetchable space |
| req_upstream | input | 1 | Request travels upstream |
| req_cls | input | 8 | Cache line size in DWORDs |
| req_flow | input | 1 | Flow-through mode |
| up_pf_en | input | 1 | Upstream memory read prefetch enable |
| busy | output | 1 | A request is in progress |
| fetch_valid | output | 1 | Fetch request to the target |
| fetch_addr | output | ADDR_W | DWORD address of the fetch |
| tgt_ack | input | 1 | Target accepts the fetch and returns data |
| tgt_data | input | DATA_W | Returned data word |
| tgt_disc | input | 1 | Target disconnects after this word |
| ini_valid | output | 1 | A word is available to the initiator |
| ini_data | output | DATA_W | Word at the head of the queue |
| ini_last | output | 1 | This word is the final one |
| ini_ready | input | 1 | Initiator takes the word |
| ini_term | input | 1 | Initiator ends the request |

## Verification
A stop point chosen wrongly shows at the ports as too many or too few `fetch_valid` beats. The same fault also puts `ini_last` on the wrong word. The fetch count shows it within one boundary span of acceptance, and the flag shows it at the end of the drain. A wrong state-machine state shows as `busy` staying high or falling early, or as fetches offered while the queue is full. If a termination fails to flush the queue, stale words appear as wrong data on the first delivery of the following request.

// File: rtl/rdpf_pkg.sv
package rdpf_pkg;

    typedef enum logic [2:0] {
        CMD_CFG = 3'd0,
        CMD_IO  = 3'd1,
        CMD_MEM = 3'd2,
        CMD_MRL = 3'd3,
        CMD_MRM = 3'd4
    } rd_cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_DRAIN,
        ST_FLUSH
    } pf_state_e;

endpackage

// File: rtl/rdpf_limit.sv
module rdpf_limit
    import rdpf_pkg::*;
#(
    parameter int ADDR_W    = 30,
    parameter int FLOW_SPAN = 1024,
    localparam int CNT_W    = $clog2(FLOW_SPAN) + 1
) (
    input  logic [2:0]        cmd,
    input  logic [ADDR_W-1:0] addr,
    input  logic              pref,
    input  logic              upstream,
    input  logic              up_en,
    input  logic [7:0]        cls,
    input  logic              flow,
    output logic [CNT_W-1:0]  words,
    output logic              fill_mode
);

    localparam logic [CNT_W-1:0] SPAN_C = CNT_W'(FLOW_SPAN);

    logic             prefetch;
    logic             small_line;
    logic [CNT_W-1:0] line;
    logic [CNT_W-1:0] low;

    always_comb begin
        case (rd_cmd_e'(cmd))
            CMD_MEM:          prefetch = upstream ? up_en : pref;
            CMD_MRL, CMD_MRM: prefetch = 1'b1;
            default:          prefetch = 1'b0;
        endcase
        small_line = (cls == 8'd1) || (cls == 8'd2) || (cls == 8'd4) || (cls == 8'd8);
        line       = small_line ? CNT_W'(cls) : CNT_W'(16);
        low        = addr[CNT_W-1:0];
        words      = CNT_W'(1);
        fill_mode  = 1'b0;
        if (prefetch) begin
            if (flow) begin
                words = SPAN_C - (low & (SPAN_C - CNT_W'(1)));
            end else if (rd_cmd_e'(cmd) == CMD_MRM) begin
                if (small_line) begin
                    words = (line << 1) - (low & (line - CNT_W'(1)));
                end else begin
                    fill_mode = 1'b1;
                    words     = SPAN_C - (low & (SPAN_C - CNT_W'(1)));
                end
            end else begin
                words = line - (low & (line - CNT_W'(1)));
            end
        end
    end

endmodule

// File: rtl/rdpf_fifo.sv
module rdpf_fifo #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 32,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int QCNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              push,
    input  logic [DATA_W-1:0] din,
    input  logic              pop,
    output logic [DATA_W-1:0] dout,
    output logic              full,
    output logic              empty,
    output logic [QCNT_W-1:0] count
);

    localparam logic [PTR_W-1:0]  LAST_P = PTR_W'(DEPTH - 1);
    localparam logic [QCNT_W-1:0] FULL_C = QCNT_W'(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;
    logic              do_push;
    logic              do_pop;

    assign full    = (count == FULL_C);
    assign empty   = (count == '0);
    assign do_push = push && !full && !clr;
    assign do_pop  = pop && !empty && !clr;
    assign dout    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == LAST_P) ? '0 : wr_ptr + PTR_W'(1);
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == LAST_P) ? '0 : rd_ptr + PTR_W'(1);
            end
            case ({do_push, do_pop})
                2'b10:   count <= count + QCNT_W'(1);
                2'b01:   count <= count - QCNT_W'(1);
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/rdpf_ctrl.sv
module rdpf_ctrl
    import rdpf_pkg::*;
#(
    parameter int ADDR_W    = 30,
    parameter int DATA_W    = 32,
    parameter int DEPTH     = 32,
    parameter int FLOW_SPAN = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_cmd,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_pref,
    input  logic              req_upstream,
    input  logic [7:0]        req_cls,
    input  logic              req_flow,
    input  logic              up_pf_en,
    output logic              busy,
    output logic              fetch_valid,
    output logic [ADDR_W-1:0] fetch_addr,
    input  logic              tgt_ack,
    input  logic [DATA_W-1:0] tgt_data,
    input  logic              tgt_disc,
    output logic              ini_valid,
    output logic [DATA_W-1:0] ini_data,
    output logic              ini_last,
    input  logic              ini_ready,
    input  logic              ini_term
);

    localparam int CNT_W  = $clog2(FLOW_SPAN) + 1;
    localparam int QCNT_W = $clog2(DEPTH + 1);

    pf_state_e         state;
    pf_state_e         state_nx;
    logic [ADDR_W-1:0] base_q;
    logic [CNT_W-1:0]  limit_q;
    logic [CNT_W-1:0]  issued_q;
    logic              fill_q;
    logic [CNT_W-1:0]  limit_w;
    logic              fill_w;
    logic              q_full;
    logic              q_empty;
    logic [QCNT_W-1:0] q_count;
    logic              q_clr;
    logic              push;
    logic              pop;
    logic              final_fetch;

    rdpf_limit #(
        .ADDR_W    (ADDR_W),
        .FLOW_SPAN (FLOW_SPAN)
    ) u_limit (
        .cmd       (req_cmd),
        .addr      (req_addr),
        .pref      (req_pref),
        .upstream  (req_upstream),
        .up_en     (up_pf_en),
        .cls       (req_cls),
        .flow      (req_flow),
        .words     (limit_w),
        .fill_mode (fill_w)
    );

    rdpf_fifo #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH)
    ) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (q_clr),
        .push  (push),
        .din   (tgt_data),
        .pop   (pop),
        .dout  (ini_data),
        .full  (q_full),
        .empty (q_empty),
        .count (q_count)
    );

    assign push        = fetch_valid && tgt_ack;
    assign pop         = ini_valid && ini_ready && !ini_term;
    assign final_fetch = push && (tgt_disc || (issued_q + CNT_W'(1) == limit_q));

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (req_valid) state_nx = ST_FETCH;
            end
            ST_FETCH: begin
                if (ini_term)                 state_nx = ST_FLUSH;
                else if (final_fetch)         state_nx = ST_DRAIN;
                else if (fill_q && q_full)    state_nx = ST_DRAIN;
            end
            ST_DRAIN: begin
                if (ini_term)                 state_nx = ST_FLUSH;
                else if (q_empty || (pop && q_count == QCNT_W'(1)))
                                              state_nx = ST_IDLE;
            end
            ST_FLUSH: state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // request context and fetch counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q   <= '0;
            limit_q  <= '0;
            fill_q   <= 1'b0;
            issued_q <= '0;
        end else if (state == ST_IDLE && req_valid) begin
            base_q   <= req_addr;
            limit_q  <= limit_w;
            fill_q   <= fill_w;
            issued_q <= '0;
        end else if (push) begin
            issued_q <= issued_q + CNT_W'(1);
        end
    end

    // outputs
    always_comb begin
        busy        = (state != ST_IDLE);
        fetch_valid = (state == ST_FETCH) && !q_full;
        fetch_addr  = base_q + ADDR_W'(issued_q);
        ini_valid   = ((state == ST_FETCH) || (state == ST_DRAIN)) && !q_empty;
        ini_last    = ini_valid && (state == ST_DRAIN) && (q_count == QCNT_W'(1));
        q_clr       = (state == ST_FLUSH);
    end

endmodule

// File: rtl/rdpf_ctrl_chk.sv
module rdpf_ctrl_chk #(
    parameter int ADDR_W = 30
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              fetch_valid,
    input logic [ADDR_W-1:0] fetch_addr,
    input logic              tgt_ack,
    input logic              tgt_disc,
    input logic              ini_valid,
    input logic              ini_last,
    input logic              ini_ready,
    input logic              ini_term,
    input logic              q_full
);

    p_idle_quiet_r14: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!fetch_valid && !ini_valid));

    p_last_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ini_last |-> ini_valid);

    p_last_drains_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ini_last && ini_ready && !ini_term) |=> !ini_valid);

    p_no_fetch_full_r11: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid |-> !q_full);

    p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && tgt_ack && !tgt_disc && !ini_term)
        |=> (!fetch_valid || fetch_addr == $past(fetch_addr) + ADDR_W'(1)));

    p_fetch_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && !tgt_ack && !ini_term) |=> (fetch_valid && $stable(fetch_addr)));

    p_disc_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && tgt_ack && tgt_disc) |=> !fetch_valid);

    p_term_flush_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (ini_term && busy) |=> (!ini_valid && !fetch_valid));

endmodule

bind rdpf_ctrl rdpf_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .fetch_valid (fetch_valid),
    .fetch_addr  (fetch_addr),
    .tgt_ack     (tgt_ack),
    .tgt_disc    (tgt_disc),
    .ini_valid   (ini_valid),
    .ini_last    (ini_last),
    .ini_ready   (ini_ready),
    .ini_term    (ini_term),
    .q_full      (q_full)
);

// File: tb/rdpf_ctrl_tb.sv
module rdpf_ctrl_tb;

    localparam int ADDR_W = 30;
    localparam int DATA_W = 32;
    localparam int DEPTH  = 32;

    typedef struct packed {
        logic [2:0]  cmd;
        logic [29:0] addr;
        logic        pf;
        logic        up;
        logic        upen;
        logic [7:0]  cls;
        logic        flow;
        logic [10:0] exp;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VEC [NV] = '{
        '{3'd0, 30'h005, 1'b1, 1'b0, 1'b1, 8'd8,  1'b0, 11'd1,  4'd1},  // R1 config read
        '{3'd1, 30'h010, 1'b1, 1'b0, 1'b1, 8'd0,  1'b0, 11'd1,  4'd1},  // R1 io read
        '{3'd2, 30'h003, 1'b0, 1'b0, 1'b1, 8'd8,  1'b0, 11'd1,  4'd1},  // R1 non-pf memory
        '{3'd2, 30'h013, 1'b1, 1'b0, 1'b0, 8'd0,  1'b0, 11'd13, 4'd2},  // R2
        '{3'd2, 30'h020, 1'b1, 1'b0, 1'b0, 8'd16, 1'b0, 11'd16, 4'd8},  // R8 aligned
        '{3'd3, 30'h006, 1'b0, 1'b0, 1'b0, 8'd4,  1'b0, 11'd2,  4'd3},  // R3
        '{3'd3, 30'h008, 1'b0, 1'b0, 1'b0, 8'd8,  1'b0, 11'd8,  4'd8},  // R8 aligned line
        '{3'd4, 30'h007, 1'b0, 1'b0, 1'b0, 8'd2,  1'b0, 11'd3,  4'd4},  // R4
        '{3'd4, 30'h000, 1'b0, 1'b0, 1'b0, 8'd8,  1'b0, 11'd16, 4'd4},  // R4
        '{3'd2, 30'h001, 1'b0, 1'b1, 1'b1, 8'd0,  1'b0, 11'd15, 4'd5},  // R5 upstream enabled
        '{3'd2, 30'h001, 1'b1, 1'b1, 1'b0, 8'd0,  1'b0, 11'd1,  4'd5},  // R5 upstream disabled
        '{3'd2, 30'h002, 1'b1, 1'b0, 1'b0, 8'd3,  1'b0, 11'd14, 4'd6},  // R6 odd cls
        '{3'd3, 30'h3F0, 1'b0, 1'b0, 1'b0, 8'd8,  1'b1, 11'd16, 4'd7},  // R7 flow
        '{3'd2, 30'h7FA, 1'b1, 1'b0, 1'b0, 8'd4,  1'b1, 11'd6,  4'd7},  // R7 flow
        '{3'd1, 30'h040, 1'b1, 1'b0, 1'b1, 8'd0,  1'b1, 11'd1,  4'd7},  // R7 non-pf in flow
        '{3'd4, 30'hFF8, 1'b0, 1'b0, 1'b0, 8'd0,  1'b0, 11'd8,  4'd12}, // R12 4KB cap
        '{3'd3, 30'h001, 1'b0, 1'b0, 1'b0, 8'd1,  1'b0, 11'd1,  4'd3}   // R3 cls 1
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [2:0]        req_cmd = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              req_pref = 1'b0;
    logic              req_upstream = 1'b0;
    logic [7:0]        req_cls = '0;
    logic              req_flow = 1'b0;
    logic              up_pf_en = 1'b0;
    logic              busy;
    logic              fetch_valid;
    logic [ADDR_W-1:0] fetch_addr;
    logic              tgt_ack = 1'b0;
    logic [DATA_W-1:0] tgt_data = '0;
    logic              tgt_disc = 1'b0;
    logic              ini_valid;
    logic [DATA_W-1:0] ini_data;
    logic              ini_last;
    logic              ini_ready = 1'b0;
    logic              ini_term = 1'b0;

    int n_checks = 0;
    int n_errors = 0;
    int n_fetch, n_word, n_bad, n_last, last_idx, n_stall, end_cyc, last_pop_cyc;
    int wd = 0;

    always #5 clk = ~clk;

    rdpf_ctrl #(
        .ADDR_W (ADDR_W), .DATA_W (DATA_W), .DEPTH (DEPTH), .FLOW_SPAN (1024)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_cmd (req_cmd),
        .req_addr (req_addr), .req_pref (req_pref), .req_upstream (req_upstream),
        .req_cls (req_cls), .req_flow (req_flow), .up_pf_en (up_pf_en), .busy (busy),
        .fetch_valid (fetch_valid), .fetch_addr (fetch_addr), .tgt_ack (tgt_ack),
        .tgt_data (tgt_data), .tgt_disc (tgt_disc), .ini_valid (ini_valid),
        .ini_data (ini_data), .ini_last (ini_last), .ini_ready (ini_ready),
        .ini_term (ini_term)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [DATA_W-1:0] pattern(input logic [ADDR_W-1:0] a);
        return 32'hA000_0000 ^ {2'b00, a};
    endfunction

    task automatic run_req(input logic [2:0] cmd, input logic [29:0] addr, input logic pf,
                           input logic up, input logic upen, input logic [7:0] cls,
                           input logic flow, input int disc_at, input int hold,
                           input int term_at, input int pulse_at);
        int cyc;
        @(negedge clk);
        req_cmd = cmd; req_addr = addr; req_pref = pf; req_upstream = up;
        up_pf_en = upen; req_cls = cls; req_flow = flow; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        n_fetch = 0; n_word = 0; n_bad = 0; n_last = 0; last_idx = -1;
        n_stall = 0; last_pop_cyc = -1; cyc = 0;
        while (busy && cyc < 4000) begin
            tgt_ack  = fetch_valid;
            tgt_data = pattern(fetch_addr);
            tgt_disc = fetch_valid && (disc_at > 0) && (n_fetch + 1 == disc_at);
            if (fetch_valid) begin
                if (fetch_addr != addr + 30'(n_fetch)) n_bad++;
                if (hold > 0 && cyc < hold && n_fetch >= DEPTH) n_stall++;
                n_fetch++;
            end
            ini_term  = (term_at > 0) && (cyc == term_at);
            ini_ready = !ini_term && (cyc >= hold);
            req_valid = (pulse_at > 0) && (cyc == pulse_at);
            if (req_valid) begin
                req_cmd = 3'd0; req_addr = 30'h200;
            end
            if (ini_valid && ini_ready) begin
                if (ini_data != pattern(addr + 30'(n_word))) n_bad++;
                if (ini_last) begin
                    n_last++;
                    last_idx = n_word;
                end
                n_word++;
                last_pop_cyc = cyc;
            end
            @(posedge clk);
            cyc++;
            @(negedge clk);
        end
        end_cyc = cyc;
        tgt_ack = 1'b0; tgt_disc = 1'b0; ini_ready = 1'b0; ini_term = 1'b0; req_valid = 1'b0;
    endtask

    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", wd, 150000);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // reset state, R14
        check(busy == 1'b0, "R14 reset busy", busy, 0);
        check(fetch_valid == 1'b0 && ini_valid == 1'b0, "R14 reset quiet",
              fetch_valid + ini_valid, 0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            run_req(VEC[i].cmd, VEC[i].addr, VEC[i].pf, VEC[i].up, VEC[i].upen,
                    VEC[i].cls, VEC[i].flow, 0, 0, 0, 0);
            check(n_fetch == int'(VEC[i].exp), $sformatf("R%0d vec%0d fetch count", VEC[i].rq, i),
                  n_fetch, int'(VEC[i].exp));
            check(n_word == int'(VEC[i].exp) && n_bad == 0,
                  $sformatf("R2 vec%0d words/data", i), n_word + 1000 * n_bad, int'(VEC[i].exp));
            check(n_last == 1 && last_idx == int'(VEC[i].exp) - 1,
                  $sformatf("R10 vec%0d last index", i), last_idx, int'(VEC[i].exp) - 1);
        end

        // R9 target disconnect on third word
        run_req(3'd2, 30'h030, 1'b1, 1'b0, 1'b0, 8'd0, 1'b0, 3, 0, 0, 0);
        check(n_fetch == 3 && n_word == 3, "R9 disconnect count", n_fetch, 3);
        check(last_idx == 2 && n_last == 1, "R10 disconnect last", last_idx, 2);

        // R12 queue-full mode: initiator stalled, fetching ends at full
        run_req(3'd4, 30'h000, 1'b0, 1'b0, 1'b0, 8'd0, 1'b0, 0, 60, 0, 0);
        check(n_fetch == DEPTH, "R12 fill count", n_fetch, DEPTH);
        check(n_word == DEPTH && n_bad == 0 && last_idx == DEPTH - 1, "R12 drain",
              n_word, DEPTH);

        // R11 stall on full in flow-through, then resume to 4KB
        run_req(3'd3, 30'h000, 1'b0, 1'b0, 1'b0, 8'd8, 1'b1, 0, 80, 0, 0);
        check(n_stall == 0, "R11 no fetch while full", n_stall, 0);
        check(n_fetch == 1024 && n_word == 1024 && n_bad == 0, "R11 resume total",
              n_fetch, 1024);

        // R13 initiator termination flushes the queue
        run_req(3'd2, 30'h040, 1'b1, 1'b0, 1'b0, 8'd0, 1'b0, 0, 100, 20, 0);
        check(n_word == 0, "R13 no words after term", n_word, 0);
        check(end_cyc == 22, "R13 busy drop", end_cyc, 22);
        run_req(3'd3, 30'h100, 1'b0, 1'b0, 1'b0, 8'd4, 1'b0, 0, 0, 0, 0);
        check(n_word == 4 && n_bad == 0, "R13 fresh data after flush", n_word + 1000 * n_bad, 4);

        // R14 request while busy ignored; busy falls one cycle after last pop
        run_req(3'd2, 30'h000, 1'b1, 1'b0, 1'b0, 8'd0, 1'b0, 0, 10, 0, 3);
        check(n_fetch == 16 && n_bad == 0, "R14 busy request ignored", n_fetch, 16);
        check(end_cyc == last_pop_cyc + 1, "R14 busy release", end_cyc, last_pop_cyc + 1);
        repeat (3) @(negedge clk);
        check(!busy && !fetch_valid, "R14 nothing queued", busy + fetch_valid, 0);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule